// File: doc/BRIEF.md
# Byte Mailbox with Full Flags and Command Marker

This block is a one-channel, byte-wide mailbox between a host register bus and a local slave processor. The host deposits a byte into an inbound holding register, and the slave collects it. The slave deposits a byte into an outbound holding register, and the host collects it. A status byte, readable from both sides, reports whether each holding register is occupied. It also reports whether the most recent host deposit was marked as a command or as data, and it holds a few spare bits that the slave can use for its own signalling.

Each side has a synchronous register port with an address, a read strobe, a write strobe and write data. Read data is registered and changes only on the clock edge that samples a read strobe. On the host side, address bit 0 selects the holding register (0) or the status byte (1), and the host address bit chosen by `CD_BIT` marks each deposit as data or a command. On the slave side, offset 0 is the holding register and offset 1 is the status byte. The slave gets an interrupt request that stays high while an inbound byte waits to be collected.

Top module: `mbox_top`

## Requirements
- R1: A host write with `h_addr[0]=0` loads `h_wdata` into the inbound register and sets the inbound-full flag (status bit 1).
- R2: A slave read at offset 0 returns the inbound register on `s_rdata` in the cycle after the strobe and clears the inbound-full flag.
- R3: On every inbound write, host address bit `CD_BIT` is stored in the command flag (status bit 3), where 0 means data and 1 means command.
- R4: A slave write at offset 0 loads the outbound register and sets the outbound-full flag (status bit 0). A host read with `h_addr[0]=0` returns that byte on `h_rdata` in the next cycle.
- R5: A host read of the outbound register clears the outbound-full flag.
- R6: A slave write to the status byte (offset 1) with data bit 0 at 0 clears the outbound-full flag. With data bit 0 at 1, the flag is unchanged.
- R7: The user bits (status bits 7..4 and bit 2) take the slave's status write data. A host write to the status byte (`h_addr[0]=1`) changes nothing. The slave cannot change status bits 1 or 3.
- R8: `s_irq` is high exactly while the inbound-full flag is set.
- R9: When a flag is set and cleared in the same cycle, it ends up set. A read in that cycle returns the register contents from before the edge.
- R10: After reset, all status bits, both read data outputs and `s_irq` are 0.
- R11: Both ports read the status byte at offset 1. A slave read at offsets 2 or above returns 0. Read data holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | HOST_AW | Host address; bit 0 selects the register, bit CD_BIT marks command or data |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data, registered |
| s_addr | input | SLV_AW | Slave register offset |
| s_rd | input | 1 | Slave read strobe |
| s_wr | input | 1 | Slave write strobe |
| s_wdata | input | DATA_W | Slave write data |
| s_rdata | output | DATA_W | Slave read data, registered |
| s_irq | output | 1 | Interrupt request to the slave while the inbound byte is uncollected |

## Verification
The bench builds the block with DATA_W=8, HOST_AW=3 and SLV_AW=2.

- **Host side:** a three-bit host address lets random accesses reach both host registers with both command-flag values, including writes that land on the read-only status byte.
- **Slave side:** a two-bit slave offset includes two unmapped offsets, so the zero read-back is exercised.
- **Stimulus:** random strobes on both ports frequently coincide. This brings the same-cycle set/clear collisions on both flags within reach, alongside directed sequences for those collisions and for the write-one-keeps rule.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int STAT_W = 8;
    localparam logic [STAT_W-1:0] USER_MASK = 8'hF4;

    typedef struct packed {
        logic [3:0] user_hi;
        logic       cmd;
        logic       user_lo;
        logic       ibf;
        logic       obf;
    } mbox_stat_t;

    typedef struct packed {
        logic wr_data;
        logic rd_data;
        logic cmd;
    } host_evt_t;

    typedef struct packed {
        logic wr_data;
        logic wr_stat;
        logic rd_data;
    } slv_evt_t;

    function automatic logic next_flag(input logic cur, input logic set, input logic clr);
        logic r;
        if (set)      r = 1'b1;
        else if (clr) r = 1'b0;
        else          r = cur;
        return r;
    endfunction

    function automatic mbox_stat_t load_user(input mbox_stat_t cur, input logic [STAT_W-1:0] b);
        mbox_stat_t r;
        r         = cur;
        r.user_hi = b[7:4];
        r.user_lo = b[2];
        return r;
    endfunction

endpackage

// File: rtl/mbox_host_if.sv
module mbox_host_if
    import mbox_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int HOST_AW = 3,
    parameter int CD_BIT  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] h_addr,
    input  logic               h_rd,
    input  logic               h_wr,
    input  logic [DATA_W-1:0]  odr,
    input  mbox_stat_t         stat,
    output host_evt_t          hev,
    output logic [DATA_W-1:0]  h_rdata
);

    logic sel_stat;
    assign sel_stat = h_addr[0];

    always_comb begin
        hev.wr_data = h_wr && !sel_stat;
        hev.rd_data = h_rd && !sel_stat;
        hev.cmd     = h_addr[CD_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_rdata <= '0;
        end else if (h_rd) begin
            if (sel_stat) h_rdata <= DATA_W'(stat);
            else          h_rdata <= odr;
        end
    end

    AST_HOST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !h_rd |=> $stable(h_rdata)) else $error("host rdata moved"); // R11

endmodule

// File: rtl/mbox_slave_if.sv
module mbox_slave_if
    import mbox_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SLV_AW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLV_AW-1:0] s_addr,
    input  logic              s_rd,
    input  logic              s_wr,
    input  logic [DATA_W-1:0] idr,
    input  mbox_stat_t        stat,
    output slv_evt_t          sev,
    output logic [DATA_W-1:0] s_rdata
);

    localparam logic [SLV_AW-1:0] OFS_DATA = SLV_AW'(0);
    localparam logic [SLV_AW-1:0] OFS_STAT = SLV_AW'(1);

    always_comb begin
        sev.wr_data = s_wr && (s_addr == OFS_DATA);
        sev.wr_stat = s_wr && (s_addr == OFS_STAT);
        sev.rd_data = s_rd && (s_addr == OFS_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_rdata <= '0;
        end else if (s_rd) begin
            if (s_addr == OFS_DATA)      s_rdata <= idr;
            else if (s_addr == OFS_STAT) s_rdata <= DATA_W'(stat);
            else                         s_rdata <= '0;
        end
    end

    AST_SLV_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !s_rd |=> $stable(s_rdata)) else $error("slave rdata moved"); // R11

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  host_evt_t         hev,
    input  slv_evt_t          sev,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic [DATA_W-1:0] s_wdata,
    output logic [DATA_W-1:0] idr,
    output logic [DATA_W-1:0] odr,
    output mbox_stat_t        stat
);

    logic obf_clr;
    assign obf_clr = hev.rd_data || (sev.wr_stat && !s_wdata[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            idr  <= '0;
            odr  <= '0;
            stat <= '0;
        end else begin
            if (hev.wr_data) begin
                idr      <= h_wdata;
                stat.cmd <= hev.cmd;
            end
            if (sev.wr_data) odr <= s_wdata;
            if (sev.wr_stat) begin
                stat.user_hi <= load_user(stat, s_wdata[STAT_W-1:0]).user_hi;
                stat.user_lo <= load_user(stat, s_wdata[STAT_W-1:0]).user_lo;
            end
            stat.ibf <= next_flag(stat.ibf, hev.wr_data, sev.rd_data);
            stat.obf <= next_flag(stat.obf, sev.wr_data, obf_clr);
        end
    end

    AST_IBF_SET: assert property (@(posedge clk) disable iff (rst)
        hev.wr_data |=> stat.ibf) else $error("ibf not set"); // R1
    AST_IBF_CLR: assert property (@(posedge clk) disable iff (rst)
        sev.rd_data && !hev.wr_data |=> !stat.ibf) else $error("ibf not cleared"); // R2
    AST_CD_LOAD: assert property (@(posedge clk) disable iff (rst)
        hev.wr_data |=> stat.cmd == $past(hev.cmd)) else $error("cmd flag wrong"); // R3
    AST_OBF_SET: assert property (@(posedge clk) disable iff (rst)
        sev.wr_data |=> stat.obf) else $error("obf not set"); // R4
    AST_OBF_HOST_CLR: assert property (@(posedge clk) disable iff (rst)
        hev.rd_data && !sev.wr_data |=> !stat.obf) else $error("obf not cleared by host"); // R5
    AST_OBF_SLV_CLR: assert property (@(posedge clk) disable iff (rst)
        sev.wr_stat && !s_wdata[0] |=> !stat.obf) else $error("obf not cleared by slave"); // R6
    AST_OBF_W1_KEEP: assert property (@(posedge clk) disable iff (rst)
        sev.wr_stat && s_wdata[0] && !hev.rd_data |=> stat.obf == $past(stat.obf))
        else $error("obf changed on write one"); // R6
    AST_IBF_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !hev.wr_data && !stat.ibf |=> !stat.ibf) else $error("ibf set without host write"); // R7
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hev.wr_data |=> $stable(stat.cmd)) else $error("cmd changed"); // R7
    AST_USER_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sev.wr_stat |=> $stable(stat.user_hi) && $stable(stat.user_lo)) else $error("user bits changed"); // R7
    AST_IBF_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        hev.wr_data && sev.rd_data |=> stat.ibf) else $error("ibf collision"); // R9

endmodule

// File: rtl/mbox_top.sv
module mbox_top
    import mbox_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int HOST_AW = 3,
    parameter int SLV_AW  = 2,
    parameter int CD_BIT  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] h_addr,
    input  logic               h_rd,
    input  logic               h_wr,
    input  logic [DATA_W-1:0]  h_wdata,
    output logic [DATA_W-1:0]  h_rdata,
    input  logic [SLV_AW-1:0]  s_addr,
    input  logic               s_rd,
    input  logic               s_wr,
    input  logic [DATA_W-1:0]  s_wdata,
    output logic [DATA_W-1:0]  s_rdata,
    output logic               s_irq
);

    host_evt_t         hev;
    slv_evt_t          sev;
    mbox_stat_t        stat;
    logic [DATA_W-1:0] idr;
    logic [DATA_W-1:0] odr;

    mbox_host_if #(.DATA_W(DATA_W), .HOST_AW(HOST_AW), .CD_BIT(CD_BIT)) u_host (
        .clk(clk), .rst(rst), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
        .odr(odr), .stat(stat), .hev(hev), .h_rdata(h_rdata)
    );

    mbox_slave_if #(.DATA_W(DATA_W), .SLV_AW(SLV_AW)) u_slave (
        .clk(clk), .rst(rst), .s_addr(s_addr), .s_rd(s_rd), .s_wr(s_wr),
        .idr(idr), .stat(stat), .sev(sev), .s_rdata(s_rdata)
    );

    mbox_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .hev(hev), .sev(sev),
        .h_wdata(h_wdata), .s_wdata(s_wdata),
        .idr(idr), .odr(odr), .stat(stat)
    );

    assign s_irq = stat.ibf;

    AST_IRQ_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        h_wr && !h_addr[0] |=> s_irq) else $error("irq missing"); // R8

endmodule

// File: tb/mbox_top_test.sv
module mbox_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] h_addr = '0;
    logic       h_rd = 1'b0, h_wr = 1'b0;
    logic [7:0] h_wdata = '0, h_rdata;
    logic [1:0] s_addr = '0;
    logic       s_rd = 1'b0, s_wr = 1'b0;
    logic [7:0] s_wdata = '0, s_rdata;
    logic       s_irq;

    always #4 clk = ~clk;

    mbox_top #(.DATA_W(8), .HOST_AW(3), .SLV_AW(2), .CD_BIT(2)) uut (
        .clk(clk), .rst(rst), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .s_addr(s_addr), .s_rd(s_rd),
        .s_wr(s_wr), .s_wdata(s_wdata), .s_rdata(s_rdata), .s_irq(s_irq)
    );

    int   n_tests = 0;
    int   n_fail  = 0;
    logic done    = 1'b0;

    logic [7:0] m_idr, m_odr, m_user, e_h, e_s;
    logic       m_ibf, m_obf, m_cd;

    function automatic logic [7:0] stat_byte(input logic [7:0] u, input logic cd,
                                             input logic ibf, input logic obf);
        return {u[7:4], cd, u[2], ibf, obf};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] ha, input logic hr, input logic hw, input logic [7:0] hd,
                        input logic [1:0] sa, input logic sr, input logic sw, input logic [7:0] sd);
        logic hwd, hrd, swd, sws, srd;
        string hreq, sreq;
        h_addr = ha; h_rd = hr; h_wr = hw; h_wdata = hd;
        s_addr = sa; s_rd = sr; s_wr = sw; s_wdata = sd;
        hwd = hw && !ha[0];
        hrd = hr && !ha[0];
        swd = sw && (sa == 2'd0);
        sws = sw && (sa == 2'd1);
        srd = sr && (sa == 2'd0);
        hreq = "R11"; sreq = "R11";
        if (hr) begin
            if (ha[0]) e_h = stat_byte(m_user, m_cd, m_ibf, m_obf);
            else begin e_h = m_odr; hreq = "R4"; end
        end
        if (sr) begin
            if (sa == 2'd0) begin e_s = m_idr; sreq = "R2"; end
            else if (sa == 2'd1) e_s = stat_byte(m_user, m_cd, m_ibf, m_obf);
            else e_s = 8'h00;
        end
        if (hwd) begin m_idr = hd; m_cd = ha[2]; end
        if (swd) m_odr = sd;
        if (sws) m_user = sd & 8'hF4;
        m_ibf = hwd ? 1'b1 : (srd ? 1'b0 : m_ibf);
        m_obf = swd ? 1'b1 : ((hrd || (sws && !sd[0])) ? 1'b0 : m_obf);
        @(negedge clk);
        check(hreq, h_rdata, e_h);
        check(sreq, s_rdata, e_s);
        check("R8", {7'd0, s_irq}, {7'd0, m_ibf});
        h_rd = 1'b0; h_wr = 1'b0; s_rd = 1'b0; s_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_idr = 0; m_odr = 0; m_user = 0; m_ibf = 0; m_obf = 0; m_cd = 0; e_h = 0; e_s = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10", h_rdata, 8'h00);
        check("R10", s_rdata, 8'h00);
        check("R10", {7'd0, s_irq}, 8'h00);
        step(3'd1, 1, 0, 8'h00, 2'd1, 1, 0, 8'h00);
        check("R10", h_rdata, 8'h00);
        // R3: command write at host address 4
        step(3'd4, 0, 1, 8'h5A, 2'd0, 0, 0, 8'h00);
        step(3'd0, 0, 0, 8'h00, 2'd1, 1, 0, 8'h00);
        check("R3", s_rdata, 8'h0A);
        // R2: collect byte, flag clears
        step(3'd0, 0, 0, 8'h00, 2'd0, 1, 0, 8'h00);
        check("R2", s_rdata, 8'h5A);
        // R7: host write to status ignored
        step(3'd1, 0, 1, 8'hFF, 2'd0, 0, 0, 8'h00);
        step(3'd1, 1, 0, 8'h00, 2'd0, 0, 0, 8'h00);
        check("R7", h_rdata, 8'h08);
        // R7: slave user bits, cannot touch ibf/cmd
        step(3'd0, 0, 0, 8'h00, 2'd1, 0, 1, 8'hF2);
        step(3'd1, 1, 0, 8'h00, 2'd0, 0, 0, 8'h00);
        check("R7", h_rdata, 8'hF8);
        // R4 then R6 write-one keeps
        step(3'd0, 0, 0, 8'h00, 2'd0, 0, 1, 8'h33);
        step(3'd0, 0, 0, 8'h00, 2'd1, 0, 1, 8'hF5);
        step(3'd1, 1, 0, 8'h00, 2'd0, 0, 0, 8'h00);
        check("R6", h_rdata, 8'hFD);
        // R6 write-zero clears
        step(3'd0, 0, 0, 8'h00, 2'd1, 0, 1, 8'hF4);
        step(3'd1, 1, 0, 8'h00, 2'd0, 0, 0, 8'h00);
        check("R6", h_rdata, 8'hFC);
        // R9: slave load and host read same cycle
        step(3'd0, 1, 0, 8'h00, 2'd0, 0, 1, 8'h44);
        check("R9", h_rdata, 8'h33);
        step(3'd1, 1, 0, 8'h00, 2'd0, 0, 0, 8'h00);
        check("R9", h_rdata, 8'hFD);
        // R9: host deposit and slave collect same cycle
        step(3'd0, 0, 1, 8'h11, 2'd0, 1, 0, 8'h00);
        check("R9", s_rdata, 8'h5A);
        check("R9", {7'd0, s_irq}, 8'h01);
        // R5: host read clears outbound flag
        step(3'd0, 1, 0, 8'h00, 2'd0, 0, 0, 8'h00);
        check("R5", h_rdata, 8'h44);
        step(3'd1, 1, 0, 8'h00, 2'd0, 0, 0, 8'h00);
        check("R5", h_rdata, 8'hF6);
        // R11: unmapped slave offset
        step(3'd0, 0, 0, 8'h00, 2'd3, 1, 0, 8'h00);
        check("R11", s_rdata, 8'h00);
        // R1: random mix against the model
        for (int i = 0; i < 3000; i++) begin
            step(3'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                 2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule